// File: doc/BRIEF.md
# Frame-Difference Correlated Double Sampler

This block removes the fixed per-pixel offset from a pixel sensor by subtracting, for every pixel, the value that pixel held one frame earlier. Each sensor matrix feeds its own lane with a pixel-serial stream. A sample carries a start-of-frame marker and a frame/row/column tag. The lane stores every sample in a frame-long delay memory. When the same pixel arrives in the following frame, the old sample is read out at the same time as the new one is written. The signed difference then leaves on the output stream with the tag unchanged.

Lanes are fully independent. Each lane has its own delay memory, pixel counter, priming state and error flag, so matrices read out in parallel can drift in phase or pause without affecting one another. The matrix size is a parameter. Full-size sensors use 256 by 256 pixels; small matrices keep simulation short. No output is produced until a lane has stored one complete frame. A lane whose frames do not contain exactly the expected number of pixels latches an error flag.

Top module: `frame_cds_top`

## Requirements
- R1: For every emitted pixel, the output difference equals the current 12-bit unsigned sample minus the sample stored for the same pixel index in the previous frame, as a 13-bit two's-complement value; the extremes +4095 and -4095 are represented exactly.
- R2: A sample presented with its valid high in clock cycle k produces its output (if any) in cycle k+2, and the output frame/row/column tag equals the tag presented with that sample.
- R3: After reset, a lane emits nothing until a sample has been written at pixel index PIX_COUNT-1 (the last pixel of a frame); emission starts with the sample after that one.
- R4: Each lane accepts a new sample on every clock cycle, with no required idle cycles between samples.
- R5: Lanes are independent: stimulus, gaps and errors on one lane do not change the outputs or error flag of any other lane.
- R6: A sample marked start-of-frame is stored at pixel index 0, and each following unmarked sample takes the next index, so a marked sample realigns a lane after a disturbed frame.
- R7: A start-of-frame sample that arrives when the lane has seen a number of samples other than 0 or PIX_COUNT since the previous frame start sets that lane's error flag in the next cycle.
- R8: An unmarked sample that arrives after PIX_COUNT samples of the current frame sets that lane's error flag in the next cycle and is stored at pixel index 0 as the first pixel of a new frame.
- R9: The error flag stays set until reset; reset (rstN low) clears all output valids, all error flags and the priming state of every lane.
- R10: Cycles with valid low change neither the pixel index nor the stored frame, and produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | LANES | Sample valid, one bit per lane |
| inSof | input | LANES | Start-of-frame marker, one bit per lane |
| inSample | input | LANES*SAMPLE_W | Unsigned ADC samples, lane l in bits [l*SAMPLE_W +: SAMPLE_W] |
| inFrame | input | LANES*FRAME_W | Frame tag per lane |
| inRow | input | LANES*ROW_W | Row tag per lane |
| inCol | input | LANES*COL_W | Column tag per lane |
| outValid | output | LANES | Difference valid per lane |
| outDiff | output | LANES*(SAMPLE_W+1) | Signed frame difference per lane |
| outFrame | output | LANES*FRAME_W | Frame tag of the emitted pixel |
| outRow | output | LANES*ROW_W | Row tag of the emitted pixel |
| outCol | output | LANES*COL_W | Column tag of the emitted pixel |
| errFlag | output | LANES | Sticky pixel-count error per lane |

## Verification
A difference and its tag appear exactly two cycles after the sample is accepted. An error flag rises one cycle after the offending sample. The bench predicts both with a behavioural per-lane model: an array of stored samples, a count and a priming bit. Expected outputs wait in a two-slot delay in the bench, and the error expectation is read one cycle after the model updates. On every falling edge the bench compares valid, difference, tag and error for all four lanes against the slot due in that cycle. It does this through reset, the first unprimed frame, back-to-back and gapped streams, a short frame, an overlong frame and realignment.

// File: rtl/cds_pkg.sv
package cds_pkg;

  // Per-cycle strobes from a lane's control to its datapath.
  typedef struct packed {
    logic wr;    // a sample is accepted this cycle
    logic emit;  // the accepted sample has a valid previous-frame partner
    logic last;  // the accepted sample lands on the final pixel index
  } laneStrobe_t;

endpackage

// File: rtl/cds_ctrl.sv
module cds_ctrl #(
  parameter int PIX_COUNT = 256,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSof,
  output cds_pkg::laneStrobe_t strobe,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic                 errFlag
);

  logic [CNT_W-1:0] pixCnt;
  logic             primed;
  logic             atLimit;
  logic             startNew;
  logic             badCount;

  always_comb begin
    atLimit     = (pixCnt == CNT_W'(PIX_COUNT));
    startNew    = inSof || atLimit;
    wrAddr      = startNew ? '0 : pixCnt[ADDR_W-1:0];
    badCount    = inValid && (inSof ? ((pixCnt != '0) && !atLimit) : atLimit);
    strobe.wr   = inValid;
    strobe.emit = inValid && primed;
    strobe.last = inValid && (wrAddr == ADDR_W'(PIX_COUNT - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      primed  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (inValid) begin
        pixCnt <= startNew ? CNT_W'(1) : pixCnt + CNT_W'(1);
      end
      if (strobe.last) begin
        primed <= 1'b1;
      end
      if (badCount) begin
        errFlag <= 1'b1;
      end
    end
  end

  // R8: the count of a frame never runs past the frame size
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    pixCnt <= CNT_W'(PIX_COUNT));

  // R9: once raised, the error flag holds until reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R3: priming only follows a write to the last pixel index
  p_prime_after_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(primed) |-> $past(strobe.last));

  // R6: a marked sample restarts the frame count
  p_sof_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> (pixCnt == CNT_W'(1)));

  // R10: idle cycles leave the count alone
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(pixCnt));

endmodule

// File: rtl/cds_datapath.sv
module cds_datapath #(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_W   = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int PIX_COUNT = 256,
  parameter int ADDR_W    = 8,
  localparam int DIFF_W   = SAMPLE_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cds_pkg::laneStrobe_t strobe,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [SAMPLE_W-1:0]  inSample,
  input  logic [FRAME_W-1:0]   inFrame,
  input  logic [ROW_W-1:0]     inRow,
  input  logic [COL_W-1:0]     inCol,
  output logic                 outValid,
  output logic [DIFF_W-1:0]    outDiff,
  output logic [FRAME_W-1:0]   outFrame,
  output logic [ROW_W-1:0]     outRow,
  output logic [COL_W-1:0]     outCol
);

  logic [SAMPLE_W-1:0] frameMem [PIX_COUNT];
  logic [SAMPLE_W-1:0] prevSample;

  logic                s1Valid;
  logic [SAMPLE_W-1:0] s1Sample;
  logic [FRAME_W-1:0]  s1Frame;
  logic [ROW_W-1:0]    s1Row;
  logic [COL_W-1:0]    s1Col;

  // Frame delay: the old sample is read in the same cycle the new one lands.
  always_ff @(posedge clk) begin
    if (strobe.wr) begin
      frameMem[wrAddr] <= inSample;
    end
    prevSample <= frameMem[wrAddr];
  end

  // Stage 1: capture the current sample and its tag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Sample <= '0;
      s1Frame  <= '0;
      s1Row    <= '0;
      s1Col    <= '0;
    end else begin
      s1Valid <= strobe.emit;
      if (strobe.wr) begin
        s1Sample <= inSample;
        s1Frame  <= inFrame;
        s1Row    <= inRow;
        s1Col    <= inCol;
      end
    end
  end

  // Stage 2: subtract and present.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outDiff  <= '0;
      outFrame <= '0;
      outRow   <= '0;
      outCol   <= '0;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) begin
        outDiff  <= {1'b0, s1Sample} - {1'b0, prevSample};
        outFrame <= s1Frame;
        outRow   <= s1Row;
        outCol   <= s1Col;
      end
    end
  end

  // R3: emission is only requested together with a write
  p_emit_writes_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> strobe.wr);

  // R2: an output is due exactly two cycles after the emitted sample
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.emit, 2));

  // R10: a sample with no partner never surfaces two cycles later
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> ##1 !outValid);

endmodule

// File: rtl/frame_cds_top.sv
module frame_cds_top #(
  parameter int LANES     = 4,
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_W   = 8,
  parameter int ROWS      = 16,
  parameter int COLS      = 16,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int DIFF_W   = SAMPLE_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0]            inSof,
  input  logic [LANES*SAMPLE_W-1:0]   inSample,
  input  logic [LANES*FRAME_W-1:0]    inFrame,
  input  logic [LANES*ROW_W-1:0]      inRow,
  input  logic [LANES*COL_W-1:0]      inCol,
  output logic [LANES-1:0]            outValid,
  output logic [LANES*DIFF_W-1:0]     outDiff,
  output logic [LANES*FRAME_W-1:0]    outFrame,
  output logic [LANES*ROW_W-1:0]      outRow,
  output logic [LANES*COL_W-1:0]      outCol,
  output logic [LANES-1:0]            errFlag
);

  localparam int PIX_COUNT = ROWS * COLS;
  localparam int ADDR_W    = (PIX_COUNT > 1) ? $clog2(PIX_COUNT) : 1;
  localparam int CNT_W     = $clog2(PIX_COUNT + 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cds_pkg::laneStrobe_t laneStrobe;
    logic [ADDR_W-1:0]    laneAddr;

    cds_ctrl #(
      .PIX_COUNT(PIX_COUNT),
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W)
    ) u_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .inValid(inValid[l]),
      .inSof  (inSof[l]),
      .strobe (laneStrobe),
      .wrAddr (laneAddr),
      .errFlag(errFlag[l])
    );

    cds_datapath #(
      .SAMPLE_W (SAMPLE_W),
      .FRAME_W  (FRAME_W),
      .ROW_W    (ROW_W),
      .COL_W    (COL_W),
      .PIX_COUNT(PIX_COUNT),
      .ADDR_W   (ADDR_W)
    ) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (laneStrobe),
      .wrAddr  (laneAddr),
      .inSample(inSample[l*SAMPLE_W +: SAMPLE_W]),
      .inFrame (inFrame[l*FRAME_W +: FRAME_W]),
      .inRow   (inRow[l*ROW_W +: ROW_W]),
      .inCol   (inCol[l*COL_W +: COL_W]),
      .outValid(outValid[l]),
      .outDiff (outDiff[l*DIFF_W +: DIFF_W]),
      .outFrame(outFrame[l*FRAME_W +: FRAME_W]),
      .outRow  (outRow[l*ROW_W +: ROW_W]),
      .outCol  (outCol[l*COL_W +: COL_W])
    );
  end

endmodule

// File: tb/frame_cds_top_tb.sv
module frame_cds_top_tb;

  localparam int LANES    = 4;
  localparam int SAMPLE_W = 12;
  localparam int FRAME_W  = 4;
  localparam int ROWS     = 4;
  localparam int COLS     = 4;
  localparam int ROW_W    = 2;
  localparam int COL_W    = 2;
  localparam int DIFF_W   = SAMPLE_W + 1;
  localparam int N        = ROWS * COLS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                       rstN = 1'b0;
  logic [LANES-1:0]           inValid = '0;
  logic [LANES-1:0]           inSof = '0;
  logic [LANES*SAMPLE_W-1:0]  inSample = '0;
  logic [LANES*FRAME_W-1:0]   inFrame = '0;
  logic [LANES*ROW_W-1:0]     inRow = '0;
  logic [LANES*COL_W-1:0]     inCol = '0;
  logic [LANES-1:0]           outValid;
  logic [LANES*DIFF_W-1:0]    outDiff;
  logic [LANES*FRAME_W-1:0]   outFrame;
  logic [LANES*ROW_W-1:0]     outRow;
  logic [LANES*COL_W-1:0]     outCol;
  logic [LANES-1:0]           errFlag;

  frame_cds_top #(
    .LANES(LANES), .SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W), .ROWS(ROWS), .COLS(COLS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSample(inSample),
    .inFrame(inFrame), .inRow(inRow), .inCol(inCol), .outValid(outValid),
    .outDiff(outDiff), .outFrame(outFrame), .outRow(outRow), .outCol(outCol),
    .errFlag(errFlag)
  );

  int    checks = 0;
  int    errors = 0;
  string curTag = "R9";

  // stimulus state per lane
  int pix[LANES];
  int fnum[LANES];
  int lenF[LANES];
  bit useSof[LANES];
  bit gapOn[LANES];
  bit restoreLen[LANES];

  // behavioural reference model per lane
  int prevV[LANES][N];
  int mCnt[LANES];
  bit mPrimed[LANES];
  bit mErr[LANES];

  // two-slot expectation delay
  bit p1V[LANES], p2V[LANES];
  int p1D[LANES], p2D[LANES];
  int p1T[LANES], p2T[LANES];

  logic [15:0] lfsr = 16'hACE1;

  function automatic int sampleOf(int l, int f, int p);
    if (p == 0) return (f % 2 == 1) ? 4095 : 0;
    return (l * 977 + f * 131 + p * 29 + p * p * 7) % 4096;
  endfunction

  task automatic fail(string tag, int l, string what, int act, int exp);
    errors++;
    $display("FAIL %s lane %0d %s: actual=%0d expected=%0d", tag, l, what, act, exp);
  endtask

  task automatic doChecks();
    for (int l = 0; l < LANES; l++) begin
      logic signed [DIFF_W-1:0] d;
      int actTag;
      d = outDiff[l*DIFF_W +: DIFF_W];
      actTag = int'({outFrame[l*FRAME_W +: FRAME_W], outRow[l*ROW_W +: ROW_W],
                     outCol[l*COL_W +: COL_W]});
      checks++;
      if (outValid[l] !== p2V[l]) fail(curTag, l, "outValid", int'(outValid[l]), int'(p2V[l]));
      if (p2V[l] && outValid[l]) begin
        checks++;  // R1 difference value
        if (int'(d) != p2D[l]) fail("R1", l, "outDiff", int'(d), p2D[l]);
        checks++;  // R2 tag travels with the data
        if (actTag != p2T[l]) fail("R2", l, "tag", actTag, p2T[l]);
      end
      checks++;
      if (errFlag[l] !== mErr[l]) fail(curTag, l, "errFlag", int'(errFlag[l]), int'(mErr[l]));
    end
  endtask

  task automatic applyAndModel();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int l = 0; l < LANES; l++) begin
      bit v;
      v = !(gapOn[l] && lfsr[l*3]);
      p1V[l] = 1'b0;
      p1D[l] = 0;
      p1T[l] = 0;
      inValid[l] = v;
      if (v) begin
        int s, addr, tag;
        bit sof;
        s   = sampleOf(l, fnum[l], pix[l]);
        sof = useSof[l] && (pix[l] == 0);
        tag = ((fnum[l] % 16) << 4) | (((pix[l] / COLS) % ROWS) << 2) | (pix[l] % COLS);
        inSof[l] = sof;
        inSample[l*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(s);
        inFrame[l*FRAME_W +: FRAME_W]    = FRAME_W'(tag >> 4);
        inRow[l*ROW_W +: ROW_W]          = ROW_W'((tag >> 2) & 3);
        inCol[l*COL_W +: COL_W]          = COL_W'(tag & 3);
        // reference model
        if (sof) begin
          if (mCnt[l] != 0 && mCnt[l] != N) mErr[l] = 1'b1;
          addr = 0;
          mCnt[l] = 1;
        end else if (mCnt[l] == N) begin
          mErr[l] = 1'b1;
          addr = 0;
          mCnt[l] = 1;
        end else begin
          addr = mCnt[l];
          mCnt[l]++;
        end
        p1V[l] = mPrimed[l];
        p1D[l] = s - prevV[l][addr];
        p1T[l] = tag;
        prevV[l][addr] = s;
        if (addr == N - 1) mPrimed[l] = 1'b1;
        // advance stimulus cursor
        pix[l]++;
        if (pix[l] == lenF[l]) begin
          pix[l] = 0;
          fnum[l]++;
          if (restoreLen[l]) begin
            lenF[l] = N;
            restoreLen[l] = 1'b0;
          end
        end
      end else begin
        inSof[l] = 1'b0;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) doChecks();
    p2V = p1V;
    p2D = p1D;
    p2T = p1T;
    applyAndModel();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = '0;
    inSof = '0;
    for (int l = 0; l < LANES; l++) begin
      mCnt[l] = 0; mPrimed[l] = 1'b0; mErr[l] = 1'b0;
      p1V[l] = 1'b0; p2V[l] = 1'b0;
      pix[l] = 0; fnum[l] = 0; lenF[l] = N;
      useSof[l] = 1'b1; gapOn[l] = 1'b0; restoreLen[l] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    curTag = "R9";           // reset state: no valid, no error
    run(3);
    curTag = "R3";           // first frame after reset emits nothing
    run(N);
    curTag = "R4";           // back-to-back frames, extremes of the difference
    run(2 * N + 2);
    curTag = "R10";          // gaps on lanes 0 and 3, lanes drift apart
    gapOn[0] = 1'b1;
    gapOn[3] = 1'b1;
    run(3 * N);
    curTag = "R7";           // short frame on lane 1 only; other lanes stay clean (R5)
    pix[1] = 0;
    lenF[1] = 5;
    restoreLen[1] = 1'b1;
    run(2 * N);
    curTag = "R8";           // overlong frames without markers on lane 2
    useSof[2] = 1'b0;
    pix[2] = 0;
    lenF[2] = N + 3;
    run(3 * N);
    curTag = "R6";           // markers return and realign lane 2
    useSof[2] = 1'b1;
    pix[2] = 0;
    lenF[2] = N;
    run(3 * N);
    curTag = "R5";           // lanes at rest while others keep running
    gapOn[1] = 1'b1;
    run(2 * N);
    doReset();
    curTag = "R9";           // second reset clears flags and priming
    run(2);
    curTag = "R3";
    run(N);
    curTag = "R1";
    run(2 * N + 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule